// File: doc/BRIEF.md
# TDM Frame Pulse Detector and Timing Generator

This block sits at the front of a time-division-multiplexed serial switch. It runs from the master clock, which is nominally 8.192 MHz. It watches an external frame pulse and turns it into a one-cycle internal frame-start strobe. It also keeps a free-running count of clocks within the frame and derives a channel index from that count for a selected stream rate.

The pulse style is worked out from the line itself. The idle level fills most of the frame, and the pulse is the short run of the opposite level. The block therefore decides on its own whether the pulse is active-low or active-high. A control bit sets the expected pulse width to one clock (the default) or two clocks. A pulse of any other short width raises a width error and does not move the frame alignment.

Lock is declared when properly sized pulses arrive one frame apart. Lock is lost, with a missing-pulse flag, when a scheduled pulse does not arrive. A second control bit selects rising-edge alignment. That bit must be one: while it is zero, the block reports a configuration error and never locks.

The frame boundary is the cycle after the last clock of a valid pulse.

Top module: `tdm_frame_timer`

## Requirements
- R1: After a synchronous active-high reset, `cyc_cnt` is 0 and `frame_start`, `locked`, `width_err`, `miss_err` and `fp_active_high` are all 0. The control bits take their defaults: width one clock, edge-alignment bit 0 (so `cfg_err` is 1), and rate code 0.
- R2: Without a valid pulse, `cyc_cnt` rises by one each clock and wraps from FRAME_CYCLES-1 to 0. `frame_start` is 1 for exactly the cycles in which `cyc_cnt` is 0, outside reset.
- R3: A valid pulse realigns the frame. A valid pulse is a short run of one level, no longer than half a frame, whose length equals the configured width and which follows a run of the other level at least half a frame long. In the cycle after its last clock, `frame_start` is 1 and `cyc_cnt` is 0.
- R4: At the end of every short pulse, `fp_active_high` takes the level of that pulse: 1 for a high pulse and 0 for a low pulse.
- R5: The pulse width is set by `cfg_wide`, written with `cfg_we`: 0 means one clock and 1 means two clocks. A short pulse of a different width sets `width_err` and leaves the counter running unaltered. The next valid pulse clears `width_err`.
- R6: With the edge-alignment bit at 1, `locked` rises when a valid pulse ends exactly one frame after the previous valid pulse. `locked` only rises in a cycle where `frame_start` is 1.
- R7: While locked, if no valid pulse ends at the scheduled boundary, `locked` falls and `miss_err` is set in the boundary cycle. `miss_err` clears when lock is regained.
- R8: While the edge-alignment bit (`cfg_rise`) is 0, `cfg_err` is 1 and `locked` is 0 from the following cycle onward.
- R9: `chan_idx` equals `cyc_cnt` shifted right by (FRAME log2 - MIN_CH_LOG - rate code). Rate codes 0, 1, 2 and 3 select 2, 4, 8 and 16 Mb/s. With the default sizes these give 32, 64, 128 and 256 channels.
- R10: A valid pulse that ends anywhere other than the scheduled boundary realigns the frame and clears `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 1 | External frame pulse line, either polarity |
| cfg_we | input | 1 | Loads the three control fields below |
| cfg_wide | input | 1 | Expected pulse width: 0 = one clock, 1 = two clocks |
| cfg_rise | input | 1 | Edge-alignment bit; must be 1 for lock |
| cfg_rate | input | 2 | Stream rate code, 0..3 = 2/4/8/16 Mb/s |
| frame_start | output | 1 | One-cycle frame boundary strobe |
| cyc_cnt | output | $clog2(FRAME_CYCLES) | Clock count within the frame |
| chan_idx | output | MIN_CH_LOG+3 | Channel index for the selected rate |
| locked | output | 1 | Frame pulses arriving on schedule |
| fp_active_high | output | 1 | Detected pulse level |
| width_err | output | 1 | Last short pulse had the wrong width |
| miss_err | output | 1 | A scheduled pulse was missed while locked |
| cfg_err | output | 1 | Edge-alignment bit is 0 |

## Verification
The bench builds the block with FRAME_CYCLES = 64 and MIN_CH_LOG = 2. This gives a half-frame threshold of 32 and a base shift of 4, so a frame lasts only 64 clocks. Many hundreds of lock, miss, width-error and off-schedule events then fit in a short run, and every counter wrap is compared cycle by cycle. The small shift still covers all four rate codes and both pulse polarities, which are exercised across two reset phases.

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int FRAME_CYCLES = 1024,
  parameter int MIN_CH_LOG   = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            fp_in,
  input  logic                            cfg_we,
  input  logic                            cfg_wide,
  input  logic                            cfg_rise,
  input  logic [1:0]                      cfg_rate,
  output logic                            frame_start,
  output logic [$clog2(FRAME_CYCLES)-1:0] cyc_cnt,
  output logic [MIN_CH_LOG+2:0]           chan_idx,
  output logic                            locked,
  output logic                            fp_active_high,
  output logic                            width_err,
  output logic                            miss_err,
  output logic                            cfg_err
);
  localparam int CW   = $clog2(FRAME_CYCLES);
  localparam int CHW  = MIN_CH_LOG + 3;
  localparam int BASE = CW - MIN_CH_LOG;
  localparam int HALF = FRAME_CYCLES / 2;
  localparam logic [CW-1:0] LAST   = CW'(FRAME_CYCLES - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic          wide_q, rise_q;
  logic [1:0]    rate_q;
  logic          fp_q, prev_long, have_ref;
  logic [CW-1:0] run_len;

  wire edge_now  = fp_in != fp_q;
  wire pulse_end = edge_now && prev_long && run_len != '0 && run_len < HALF_C;
  wire good      = pulse_end && run_len == (wide_q ? CW'(2) : CW'(1));
  wire bad       = pulse_end && !good;
  wire at_last   = cyc_cnt == LAST;

  assign cfg_err = !rise_q;

  always_comb begin
    case (rate_q)
      2'd0:    chan_idx = CHW'(cyc_cnt >> BASE);
      2'd1:    chan_idx = CHW'(cyc_cnt >> (BASE - 1));
      2'd2:    chan_idx = CHW'(cyc_cnt >> (BASE - 2));
      default: chan_idx = CHW'(cyc_cnt >> (BASE - 3));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q         <= 1'b0;
      rise_q         <= 1'b0;
      rate_q         <= 2'd0;
      fp_q           <= 1'b0;
      run_len        <= '0;
      prev_long      <= 1'b0;
      have_ref       <= 1'b0;
      cyc_cnt        <= '0;
      frame_start    <= 1'b0;
      locked         <= 1'b0;
      fp_active_high <= 1'b0;
      width_err      <= 1'b0;
      miss_err       <= 1'b0;
    end else begin
      if (cfg_we) begin
        wide_q <= cfg_wide;
        rise_q <= cfg_rise;
        rate_q <= cfg_rate;
      end

      fp_q <= fp_in;
      if (edge_now) begin
        run_len   <= CW'(1);
        prev_long <= run_len >= HALF_C;
      end else if (run_len != HALF_C) begin
        run_len <= run_len + CW'(1);
      end

      if (pulse_end) fp_active_high <= fp_q;

      if (good) begin
        cyc_cnt     <= '0;
        frame_start <= 1'b1;
        have_ref    <= 1'b1;
      end else begin
        cyc_cnt     <= at_last ? '0 : cyc_cnt + CW'(1);
        frame_start <= at_last;
      end

      if (!rise_q)   locked <= 1'b0;
      else if (good) locked <= have_ref && at_last;
      else if (at_last) locked <= 1'b0;

      if (locked && at_last && !good) miss_err <= 1'b1;
      else if (good && at_last && have_ref && rise_q) miss_err <= 1'b0;

      if (bad)       width_err <= 1'b1;
      else if (good) width_err <= 1'b0;
    end
  end
endmodule

module tdm_frame_timer_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic [CW-1:0] cyc_cnt,
  input logic          locked,
  input logic          miss_err,
  input logic          cfg_err
);
  p_strobe_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> cyc_cnt == '0);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !frame_start) |-> cyc_cnt == $past(cyc_cnt) + CW'(1));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  p_lock_on_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> frame_start);

  p_miss_drops_lock_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(miss_err) |-> $fell(locked));

  p_cfg_blocks_lock_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !locked);
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .cyc_cnt(cyc_cnt),
  .locked(locked), .miss_err(miss_err), .cfg_err(cfg_err)
);

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;
  localparam int F    = 64;
  localparam int MCL  = 2;
  localparam int CW   = $clog2(F);
  localparam int HALF = F / 2;
  localparam int BASE = CW - MCL;

  logic clk = 1'b0, rst = 1'b1, fp_in = 1'b1;
  logic cfg_we = 1'b0, cfg_wide = 1'b0, cfg_rise = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic frame_start, locked, fp_active_high, width_err, miss_err, cfg_err;
  logic [CW-1:0] cyc_cnt;
  logic [MCL+2:0] chan_idx;

  always #10 clk = ~clk;

  tdm_frame_timer #(.FRAME_CYCLES(F), .MIN_CH_LOG(MCL)) u_tdm_frame_timer (
    .clk(clk), .rst(rst), .fp_in(fp_in), .cfg_we(cfg_we), .cfg_wide(cfg_wide),
    .cfg_rise(cfg_rise), .cfg_rate(cfg_rate), .frame_start(frame_start),
    .cyc_cnt(cyc_cnt), .chan_idx(chan_idx), .locked(locked),
    .fp_active_high(fp_active_high), .width_err(width_err),
    .miss_err(miss_err), .cfg_err(cfg_err));

  int checks = 0, fails = 0;
  int exp_cnt = 0;
  logic idle_lvl = 1'b1;
  logic wide_b = 1'b0, rise_b = 1'b0;
  int rate_b = 0;
  logic e_lock = 1'b0, e_miss = 1'b0, e_werr = 1'b0, e_ref = 1'b0;
  bit done = 1'b0;

  function automatic int exp_chan(int cnt, int rate);
    return cnt >> (BASE - rate);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    exp_cnt = (exp_cnt + 1) % F;
  endtask

  task automatic check_timing();
    check("R2 cyc_cnt", int'(cyc_cnt), exp_cnt);
    check("R2 frame_start", int'(frame_start), int'(exp_cnt == 0));
    check("R9 chan_idx", int'(chan_idx), exp_chan(exp_cnt, rate_b));
  endtask

  task automatic check_flags(string tag);
    check({tag, " R6 locked"}, int'(locked), int'(e_lock));
    check({tag, " R7 miss_err"}, int'(miss_err), int'(e_miss));
    check({tag, " R5 width_err"}, int'(width_err), int'(e_werr));
    check({tag, " R8 cfg_err"}, int'(cfg_err), int'(!rise_b));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      check_timing();
    end
  endtask

  task automatic pulse(int w, bit good);
    fp_in = ~idle_lvl;
    repeat (w) tick();
    fp_in = idle_lvl;
    tick();
    if (good) exp_cnt = 0;
    check_timing();
    check("R4 polarity", int'(fp_active_high), int'(!idle_lvl));
  endtask

  task automatic cfg(logic wide, logic rise, int rate);
    cfg_we = 1'b1; cfg_wide = wide; cfg_rise = rise; cfg_rate = 2'(rate);
    tick();
    cfg_we = 1'b0;
    wide_b = wide; rise_b = rise; rate_b = rate;
    if (!rise) e_lock = 1'b0;
    check("R8 cfg_err after write", int'(cfg_err), int'(!rise));
  endtask

  function automatic int cur_w();
    return wide_b ? 2 : 1;
  endfunction

  task automatic good_ontime();
    idle(F - cur_w() - 1 - exp_cnt);
    pulse(cur_w(), 1'b1);
    if (rise_b && e_ref) e_miss = 1'b0;
    e_lock = rise_b && e_ref;
    e_ref = 1'b1; e_werr = 1'b0;
    check_flags("good");
  endtask

  task automatic miss_round();
    idle(F - exp_cnt);
    if (e_lock) begin e_lock = 1'b0; e_miss = 1'b1; end
    check_flags("miss");
  endtask

  task automatic bad_ontime();
    int ww = wide_b ? 1 : 2;
    idle(F - ww - 1 - exp_cnt);
    pulse(ww, 1'b0);
    e_werr = 1'b1;
    if (e_lock) begin e_lock = 1'b0; e_miss = 1'b1; end
    check_flags("bad");
  endtask

  task automatic offsched(int g);
    idle(g);
    pulse(cur_w(), 1'b1);
    e_lock = 1'b0; e_ref = 1'b1; e_werr = 1'b0;
    check_flags("R10 offsched");
  endtask

  task automatic do_reset(logic lvl);
    rst = 1'b1; idle_lvl = lvl; fp_in = lvl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0; wide_b = 1'b0; rise_b = 1'b0; rate_b = 0;
    e_lock = 1'b0; e_miss = 1'b0; e_werr = 1'b0; e_ref = 1'b0;
    check("R1 cyc_cnt", int'(cyc_cnt), 0);
    check("R1 frame_start", int'(frame_start), 0);
    check("R1 polarity", int'(fp_active_high), 0);
    check_flags("R1");
  endtask

  initial begin
    void'($urandom(32'd1977));
    do_reset(1'b1);
    idle(F);
    // R3 realign off-phase, active-low style, default width
    idle(40);
    pulse(1, 1'b1);
    e_ref = 1'b1;
    check_flags("R3");
    good_ontime();
    // R6 lock once edge bit is set
    cfg(1'b0, 1'b1, 1);
    good_ontime();
    check("R6 locked", int'(locked), 1);
    bad_ontime();
    check("R7 miss after bad", int'(miss_err), 1);
    good_ontime();
    miss_round();
    cfg(1'b1, 1'b1, 3);
    good_ontime();
    good_ontime();
    bad_ontime();
    good_ontime();
    good_ontime();
    offsched(HALF + 3);
    check("R10 lock cleared", int'(locked), 0);
    good_ontime();
    cfg(1'b1, 1'b0, 2);
    idle(2);
    check("R8 lock forced low", int'(locked), 0);
    good_ontime();
    // second phase, active-high style, random rounds
    do_reset(1'b0);
    idle(F);
    cfg(1'b0, 1'b1, 0);
    for (int r = 0; r < 400; r++) begin
      int k = int'($urandom % 8);
      if (k < 4) good_ontime();
      else if (k == 4) miss_round();
      else if (k == 5) bad_ontime();
      else if (k == 6) offsched(HALF + int'($urandom % (F - cur_w() - 3 - exp_cnt - HALF)));
      else cfg(1'($urandom % 2), ($urandom % 4) != 0, int'($urandom % 4));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule